// File: doc/BRIEF.md
# Management Bus Command Master

This block sits between a host processor's register port and an internal management bus. Software puts a data word in a staging register, then writes one command word. That word says whether the access is a read or a write, which device to address, and which word of that device to touch. The block raises a request toward the device side and holds it until the device acknowledges. The host then polls the command register until the start bit drops.

Three outcomes are possible, and each is reported through control-register bits. A clean acknowledge clears start and busy; for a read, it also captures the returned word. An acknowledge flagged as an error sets a sticky error bit. If the device stays silent longer than a programmable number of cycles, the request is withdrawn and a sticky timeout bit is set. Only one transaction is in flight at a time.

Top module: `mcm_cmd_master`

## Requirements
- R1: After reset, every host register reads zero and `dev_req` is low.
- R2: Writing the control word (byte offset 0x0) with bit 31 set while idle starts a transaction. From the next cycle, bits 31 (start) and 28 (busy) read one and `dev_req` is high. `dev_we` follows bit 20 (1 = write, 0 = read), `dev_addr` follows bits 19:12 and `dev_off` follows bits 11:0.
- R3: The word written at byte offset 0x4 reads back there and drives `dev_wdata` for the next transaction.
- R4: When `dev_ack` is high with `dev_err` low during a request, start and busy read zero and `dev_req` is low from the next cycle. For a read, the register at byte offset 0xC then holds the `dev_rdata` value from the acknowledge cycle.
- R5: When `dev_ack` and `dev_err` are both high during a request, the transaction ends as in R4. Control bit 29 is set and the read-data register keeps its previous value.
- R6: With a non-zero limit N at byte offset 0x8, a request that gets no acknowledge in its first N cycles is dropped after the Nth cycle and control bit 30 is set. An acknowledge in the Nth cycle still completes normally.
- R7: A limit of zero disables the timeout, so the request is held until acknowledged.
- R8: While busy, writes to the control, write-data and limit registers are ignored, and the device-side fields stay stable.
- R9: Bits 29 and 30 stay set until a control write with bit 31 set is accepted, which clears both. A control write without bit 31 updates the direction, address and offset fields without starting a transaction.
- R10: Control bits 27:21 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host byte offset (bits 3:2 select the word) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from `reg_addr` |
| dev_req | output | 1 | Request held for the whole transaction |
| dev_we | output | 1 | Direction, 1 = write |
| dev_addr | output | 8 | Target device address |
| dev_off | output | 12 | Word offset inside the device |
| dev_wdata | output | 32 | Data for a write |
| dev_ack | input | 1 | Device acknowledge, sampled while `dev_req` is high |
| dev_err | input | 1 | Error response qualifying `dev_ack` |
| dev_rdata | input | 32 | Device read data, valid with `dev_ack` |

## Verification
The assertions check the following on every cycle:
- a launch raises the request;
- an acknowledge or a timeout drops it;
- an error response sets its flag without touching the read-data register;
- device-side fields stay stable while a request is held;
- the timeout event never fires with a zero limit;
- the reserved control bits read zero.

Some behaviour can only be shown by the bench's scenarios: the exact cycle a timeout lands on for a given limit, an acknowledge in the last allowed cycle winning over the timeout, flags staying set across a control write without start, and writes during a transaction leaving no trace. A scoreboard matches every request the block raises against the command the driver issued.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int DATA_W = 32;
  localparam int DEVA_W = 8;
  localparam int OFF_W  = 12;
  localparam int TMO_W  = 32;

  // Word indices of the host registers (byte offset / 4)
  localparam logic [1:0] IDX_CTRL  = 2'd0;
  localparam logic [1:0] IDX_WDATA = 2'd1;
  localparam logic [1:0] IDX_LIMIT = 2'd2;
  localparam logic [1:0] IDX_RDATA = 2'd3;

  // Control word bit positions
  localparam int B_START = 31;
  localparam int B_TMO   = 30;
  localparam int B_ERR   = 29;
  localparam int B_BUSY  = 28;
  localparam int B_DIR   = 20;
  localparam int B_DEVA  = 12;
  localparam int B_OFF   = 0;

  typedef struct packed {
    logic              dir;
    logic [DEVA_W-1:0] deva;
    logic [OFF_W-1:0]  off;
  } cmd_t;

  // Timeout hit: limit zero never expires; otherwise the Nth cycle of the request
  function automatic logic tmo_hit(input logic [TMO_W-1:0] cnt,
                                   input logic [TMO_W-1:0] lim);
    return (lim != '0) && (cnt == lim - 1'b1);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input logic start, input logic tmo,
                                                  input logic err, input logic busy,
                                                  input cmd_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_START] = start;
    w[B_TMO]   = tmo;
    w[B_ERR]   = err;
    w[B_BUSY]  = busy;
    w[B_DIR]   = c.dir;
    w[B_DEVA +: DEVA_W] = c.deva;
    w[B_OFF  +: OFF_W]  = c.off;
    return w;
  endfunction

  function automatic cmd_t ctrl_unpack(input logic [DATA_W-1:0] w);
    cmd_t c;
    c.dir  = w[B_DIR];
    c.deva = w[B_DEVA +: DEVA_W];
    c.off  = w[B_OFF +: OFF_W];
    return c;
  endfunction
endpackage

// File: rtl/mcm_timer.sv
module mcm_timer
  import mcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && tmo_hit(cnt_q, limit);
endmodule

// File: rtl/mcm_seq.sv
module mcm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic ack,
  input  logic err,
  input  logic expired,
  output logic busy,
  output logic ev_ok,
  output logic ev_err,
  output logic ev_tmo
);
  logic busy_q;

  // Acknowledge has priority over a timeout in the same cycle
  assign ev_ok  = busy_q && ack && !err;
  assign ev_err = busy_q && ack && err;
  assign ev_tmo = busy_q && !ack && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         busy_q <= 1'b0;
    else if (launch)                    busy_q <= 1'b1;
    else if (ev_ok || ev_err || ev_tmo) busy_q <= 1'b0;
  end

  assign busy = busy_q;
endmodule

// File: rtl/mcm_cmd_master.sv
module mcm_cmd_master
  import mcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dev_req,
  output logic              dev_we,
  output logic [DEVA_W-1:0] dev_addr,
  output logic [OFF_W-1:0]  dev_off,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic              dev_err,
  input  logic [DATA_W-1:0] dev_rdata
);
  logic [1:0]        widx;
  logic              busy, ev_ok, ev_err, ev_tmo, expired;
  logic              wr_ctrl, wr_wdata, wr_limit, launch;
  cmd_t              cmd_q;
  logic              flag_err_q, flag_tmo_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [TMO_W-1:0]  limit_q;

  assign widx     = reg_addr[3:2];
  assign wr_ctrl  = reg_wr_en && !busy && (widx == IDX_CTRL);
  assign wr_wdata = reg_wr_en && !busy && (widx == IDX_WDATA);
  assign wr_limit = reg_wr_en && !busy && (widx == IDX_LIMIT);
  assign launch   = wr_ctrl && reg_wdata[B_START];

  mcm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .ack(dev_ack), .err(dev_err),
    .expired(expired), .busy(busy), .ev_ok(ev_ok), .ev_err(ev_err), .ev_tmo(ev_tmo)
  );

  mcm_timer u_timer (
    .clk(clk), .rst_n(rst_n), .clear(launch), .run(busy),
    .limit(limit_q), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      flag_err_q <= 1'b0;
      flag_tmo_q <= 1'b0;
      wdata_q    <= '0;
      limit_q    <= '0;
      rdata_q    <= '0;
    end else begin
      if (wr_ctrl)  cmd_q   <= ctrl_unpack(reg_wdata);
      if (wr_wdata) wdata_q <= reg_wdata;
      if (wr_limit) limit_q <= reg_wdata[TMO_W-1:0];
      if (launch) begin
        flag_err_q <= 1'b0;
        flag_tmo_q <= 1'b0;
      end
      if (ev_err) flag_err_q <= 1'b1;
      if (ev_tmo) flag_tmo_q <= 1'b1;
      if (ev_ok && !cmd_q.dir) rdata_q <= dev_rdata;
    end
  end

  always_comb begin
    unique case (widx)
      IDX_CTRL:  reg_rdata = ctrl_pack(busy, flag_tmo_q, flag_err_q, busy, cmd_q);
      IDX_WDATA: reg_rdata = wdata_q;
      IDX_LIMIT: reg_rdata = DATA_W'(limit_q);
      default:   reg_rdata = rdata_q;
    endcase
  end

  assign dev_req   = busy;
  assign dev_we    = cmd_q.dir;
  assign dev_addr  = cmd_q.deva;
  assign dev_off   = cmd_q.off;
  assign dev_wdata = wdata_q;
endmodule

// File: rtl/mcm_chk.sv
module mcm_chk
  import mcm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              launch,
  input logic              ev_tmo,
  input logic              flag_err,
  input logic              flag_tmo,
  input logic [TMO_W-1:0]  limit,
  input logic [DATA_W-1:0] rdata_reg,
  input logic [3:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              dev_req,
  input logic              dev_ack,
  input logic              dev_err,
  input logic              dev_we,
  input logic [DEVA_W-1:0] dev_addr,
  input logic [OFF_W-1:0]  dev_off,
  input logic [DATA_W-1:0] dev_wdata
);
  a_r2_launch_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> dev_req);

  a_r4_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack) |=> !dev_req);

  a_r5_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack && dev_err) |=> flag_err);

  a_r5_err_keeps_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack && dev_err) |=> $stable(rdata_reg));

  a_r6_tmo_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> (flag_tmo && !dev_req));

  a_r7_no_tmo_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !ev_tmo);

  a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ack && !ev_tmo) |=>
      ($stable(dev_we) && $stable(dev_addr) && $stable(dev_off) && $stable(dev_wdata)));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3:2] == IDX_CTRL) |-> (reg_rdata[27:21] == '0));
endmodule

bind mcm_cmd_master mcm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .ev_tmo(ev_tmo),
  .flag_err(flag_err_q), .flag_tmo(flag_tmo_q), .limit(limit_q), .rdata_reg(rdata_q),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .dev_req(dev_req), .dev_ack(dev_ack),
  .dev_err(dev_err), .dev_we(dev_we), .dev_addr(dev_addr), .dev_off(dev_off),
  .dev_wdata(dev_wdata)
);

// File: tb/tb_mcm_cmd_master.sv
module tb_mcm_cmd_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_req, dev_we;
  logic [7:0]  dev_addr;
  logic [11:0] dev_off;
  logic [31:0] dev_wdata;
  logic        dev_ack = 1'b0;
  logic        dev_err = 1'b0;
  logic [31:0] dev_rdata = '0;

  int checks = 0;
  int errors = 0;
  logic [52:0] exp_q[$];   // {we, addr, off, wdata}
  logic [31:0] model_wdata = '0;
  logic        req_seen = 1'b0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  mcm_cmd_master dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd(input logic st, input logic we,
                                      input logic [7:0] a, input logic [11:0] o);
    return {st, 10'b0, we, a, o};
  endfunction

  // Driver: issue a launch and push the expected request onto the scoreboard
  task automatic launch(input logic we, input logic [7:0] a, input logic [11:0] o);
    exp_q.push_back({we, a, o, model_wdata});
    wr(4'h0, cmd(1'b1, we, a, o));
  endtask

  task automatic respond(input logic err, input logic [31:0] d);
    dev_ack = 1'b1; dev_err = err; dev_rdata = d;
    @(negedge clk);
    dev_ack = 1'b0; dev_err = 1'b0;
  endtask

  // Monitor: compare each new request against the scoreboard head
  always @(negedge clk) begin
    if (dev_req && !req_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected request actual=%h expected=none",
                 {dev_we, dev_addr, dev_off, dev_wdata});
      end else begin
        logic [52:0] e;
        e = exp_q.pop_front();
        if ({dev_we, dev_addr, dev_off, dev_wdata} !== e) begin
          errors++;
          $display("FAIL R2/R3: request actual=%h expected=%h",
                   {dev_we, dev_addr, dev_off, dev_wdata}, e);
        end
      end
    end
    req_seen <= dev_req;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset values
    for (int i = 0; i < 4; i++) begin
      rd(4'(i * 4), v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 req", {31'b0, dev_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 write data readback, R2 write launch
    model_wdata = 32'hCAFE_0123;
    wr(4'h4, model_wdata);
    rd(4'h4, v); chk("R3 readback", v, model_wdata);
    launch(1'b1, 8'hA5, 12'h3C7);
    rd(4'h0, v); chk("R2 busy/start", v, {1'b1, 2'b0, 1'b1, 7'b0, 1'b1, 8'hA5, 12'h3C7});
    respond(1'b0, 32'h0);
    rd(4'h0, v); chk("R4 done write", v, cmd(1'b0, 1'b1, 8'hA5, 12'h3C7));

    // R4 read with returned data
    launch(1'b0, 8'h12, 12'h004);
    @(negedge clk);
    respond(1'b0, 32'h1357_9BDF);
    chk("R4 req low", {31'b0, dev_req}, 32'h0);
    rd(4'hC, v); chk("R4 rdata", v, 32'h1357_9BDF);

    // R5 error response keeps read data
    launch(1'b0, 8'h33, 12'h010);
    respond(1'b1, 32'hDEAD_BEEF);
    rd(4'h0, v); chk("R5 err flag", v, {3'b001, 29'(cmd(1'b0, 1'b0, 8'h33, 12'h010))});
    rd(4'hC, v); chk("R5 rdata kept", v, 32'h1357_9BDF);

    // R9 control write without start keeps flags, no launch; R10 reserved bits
    wr(4'h0, 32'h0FE0_0000 | cmd(1'b0, 1'b1, 8'h77, 12'h0AB));
    rd(4'h0, v); chk("R9/R10 no-start write", v, {3'b001, 29'(cmd(1'b0, 1'b1, 8'h77, 12'h0AB))});
    chk("R9 no launch", {31'b0, dev_req}, 32'h0);

    // R6 timeout with limit 4; launch also clears error flag (R9)
    wr(4'h8, 32'd4);
    rd(4'h8, v); chk("R6 limit readback", v, 32'd4);
    launch(1'b0, 8'h44, 12'h001);
    rd(4'h0, v); chk("R9 flags cleared", v[30:29], 32'h0);
    repeat (3) @(negedge clk);
    chk("R6 req held N-1", {31'b0, dev_req}, 32'h1);
    @(negedge clk);
    chk("R6 req dropped", {31'b0, dev_req}, 32'h0);
    rd(4'h0, v); chk("R6 tmo flag", v[31:28], 4'b0100);

    // R6 acknowledge in the Nth cycle wins
    launch(1'b0, 8'h45, 12'h002);
    repeat (3) @(negedge clk);
    respond(1'b0, 32'h0000_5A5A);
    rd(4'h0, v); chk("R6 last-cycle ack", v[31:28], 4'b0000);
    rd(4'hC, v); chk("R6 last-cycle data", v, 32'h0000_5A5A);

    // R7 limit zero waits; R8 writes during busy ignored
    wr(4'h8, 32'd0);
    launch(1'b1, 8'h9C, 12'hFFF);
    wr(4'h0, cmd(1'b1, 1'b0, 8'h01, 12'h001));
    wr(4'h4, 32'h1111_1111);
    wr(4'h8, 32'd2);
    repeat (20) @(negedge clk);
    chk("R7 still waiting", {31'b0, dev_req}, 32'h1);
    chk("R8 addr stable", {24'b0, dev_addr}, 32'h9C);
    rd(4'h4, v); chk("R8 wdata unchanged", v, model_wdata);
    rd(4'h8, v); chk("R8 limit unchanged", v, 32'd0);
    rd(4'h0, v); chk("R8 ctrl unchanged", v, {1'b1, 2'b0, 1'b1, 7'b0, 1'b1, 8'h9C, 12'hFFF});
    respond(1'b0, 32'h0);
    chk("R4 end after long wait", {31'b0, dev_req}, 32'h0);

    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule